// File: doc/BRIEF.md
# Table-Driven Packet Parse-Tree Walker

The walker classifies a received frame by stepping through a decision tree held in a node table. At each step it reads a 16-bit word from the packet buffer at the current byte pointer, compares it under a mask with the data of one branch, and then either follows that branch or tries the next one. Following a branch moves the packet pointer, by an absolute or relative jump, and selects the next node and branch. The walk ends at a node flagged as last, at a key node, when a node's branch list runs out, or when a step limit is reached. The block then reports a result index and whether that index means "drop".

A walk is requested through a valid/ready handshake carrying the start node, the start byte offset and a fallback result index. A typical start offset is 12, the EtherType position, plus a per-port skip of 4 or 8 bytes. The request is taken only on a cycle where both `start_valid` and `start_ready` are high. `start_ready` is high only when the walker is idle, so a requester holds its request until it is taken. The result is a single-cycle `result_valid` pulse with no back-pressure. The receiver must capture it in that cycle. Both table read ports are combinational: an address driven in a cycle must return its data in the same cycle.

Top module: `ptw_walker`

## Requirements
- R1: After reset `start_ready` is 1. A request is taken only when `start_valid` and `start_ready` are both high. `start_ready` stays 0 from the taken request until the cycle that shows `result_valid`. Requests raised while busy are ignored.
- R2: Entry layout: the node table word at address {node, slot} holds the node header in slot 0 and branch b in slot b+1. Header bits are [9:0] default result, [11:10], [13:12], [15:14] store selectors, [16] length-store flag, [17] two-key flag, [18] last flag and [20:19] kind (1 = key node, others = decision). The first step of a walk reads the header of the start node, with the packet pointer equal to the start offset.
- R3: Branch bits are [15:0] mask, [31:16] data, [34:32] next branch, [48:35] next node, [50:49] operation, [51] relative, [52] backward, [61:53] pointer operand and [62] valid. The packet word is {byte[ptr], byte[ptr+1]}. A mask bit of 1 removes that bit from both sides. The operation codes are 0 equal, 1 not equal, 2 packet greater than data, and 3 packet less than data.
- R4: A branch with valid = 0 is followed without any compare.
- R5: Following a branch sets the pointer to the operand when the jump is absolute. A relative jump forward adds the operand and a relative jump backward subtracts it. The arithmetic is modulo 512.
- R6: A valid branch that does not match leaves the pointer unchanged and moves to the next branch of the same node. When branch index 7 (the last slot) does not match, the walk ends with the node's default result.
- R7: Each cycle of a walk performs one step: a header read, a branch evaluation or a key read. A followed branch that names the current node continues with that branch without a header step. Otherwise the next step reads the new node's header. `result_valid` is high for exactly one cycle, the cycle after the final step.
- R8: A header with the last flag set ends the walk with that header's default result, even when its kind is key.
- R9: A key node ends the walk after one more step that reads slot 1. That word holds key 0 in [15:0] and key 1 in [31:16], each key being [9:0] result and [15:13] priority. Key 1 is chosen only when the two-key flag is set and its priority is strictly greater than key 0's.
- R10: A walk that has not ended after 64 steps ends at that step with the requested fallback result and `result_timeout` = 1. `result_timeout` is 0 for every other ending.
- R11: `result_drop` is 1 exactly when the reported result index is 0.
- R12: After reset `result_valid` is 0.
- R13: The header store selectors and the length-store flag have no effect on the result or the step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Walk request present |
| start_ready | output | 1 | Walker idle, request can be taken |
| start_node | input | 14 | Node index where the walk begins |
| start_pkt | input | 9 | Byte offset where the walk begins |
| def_ptr | input | 10 | Result reported when the step limit is hit |
| pkt_addr | output | 9 | Packet buffer byte address |
| pkt_data | input | 16 | Bytes at pkt_addr and pkt_addr+1, first byte high |
| node_addr | output | 18 | Node table address {node, slot} |
| node_data | input | 64 | Node table word at node_addr |
| result_valid | output | 1 | One-cycle pulse marking a finished walk |
| result_ptr | output | 10 | Classification result index |
| result_drop | output | 1 | Result index denotes drop |
| result_timeout | output | 1 | Walk ended on the step limit |

## Verification
The bench builds small trees that follow an EtherType and protocol-byte path. It checks the result and also the exact number of cycles per walk. A design that re-read headers on same-node chaining, or that skipped the header after a node change, would show the right index after the wrong number of cycles. Each compare operation is tested at its equality boundary and with masked-out bits that differ. An inverted mask or an off-by-one ordering would then flip the branch taken. Pointer tests combine relative forward and backward jumps, an absolute jump and a wrap past byte 511; a sign or wrap error lands on the wrong bytes and misses the match. A self-loop exposes a step limit that fires one step early or late. A request raised while busy would corrupt the running walk if it were taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int NPTR_W = 14;
  localparam int PPTR_W = 9;
  localparam int RPTR_W = 10;
  localparam int BR_W   = 3;
  localparam int WORD_W = 64;
  localparam int PKT_W  = 16;
  localparam int PRIO_W = 3;

  typedef enum logic [1:0] {
    OP_EQ = 2'd0,
    OP_NE = 2'd1,
    OP_GT = 2'd2,
    OP_LT = 2'd3
  } cmp_op_e;

  localparam logic [1:0] KIND_KEY = 2'd1;

  typedef struct packed {
    logic [42:0]       pad;
    logic [1:0]        kind;
    logic              last;
    logic              two_keys;
    logic              len_store;
    logic [1:0]        ext_sel;
    logic [1:0]        byte_sel;
    logic [1:0]        search_sel;
    logic [RPTR_W-1:0] rptr;
  } hdr_t;

  typedef struct packed {
    logic              pad;
    logic              valid;
    logic [PPTR_W-1:0] npp;
    logic              back;
    logic              rel;
    logic [1:0]        op;
    logic [NPTR_W-1:0] nnode;
    logic [BR_W-1:0]   nbr;
    logic [PKT_W-1:0]  data;
    logic [PKT_W-1:0]  mask;
  } br_t;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [2:0]        rsvd;
    logic [RPTR_W-1:0] rptr;
  } key_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_BR   = 2'd2,
    S_KEY  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_branch_eval.sv
module ptw_branch_eval
  import ptw_pkg::*;
(
  input  br_t               br,
  input  logic [PKT_W-1:0]  pkt_word,
  input  logic [PPTR_W-1:0] cur_ptr,
  output logic              take,
  output logic [PPTR_W-1:0] next_ptr
);
  logic [PKT_W-1:0] pkt_m;
  logic [PKT_W-1:0] dat_m;
  logic             hit;

  always_comb begin
    pkt_m = pkt_word & ~br.mask;
    dat_m = br.data  & ~br.mask;
    case (cmp_op_e'(br.op))
      OP_EQ:   hit = (pkt_m == dat_m);
      OP_NE:   hit = (pkt_m != dat_m);
      OP_GT:   hit = (pkt_m >  dat_m);
      default: hit = (pkt_m <  dat_m);
    endcase
    take = !br.valid || hit;
  end

  always_comb begin
    if (!br.rel)      next_ptr = br.npp;
    else if (br.back) next_ptr = cur_ptr - br.npp;
    else              next_ptr = cur_ptr + br.npp;
  end
endmodule

// File: rtl/ptw_key_pick.sv
module ptw_key_pick
  import ptw_pkg::*;
(
  input  logic [2*PKT_W-1:0] key_word,
  input  logic               two_keys,
  output logic [RPTR_W-1:0]  rptr
);
  key_t k_lo;
  key_t k_hi;

  always_comb begin
    k_lo = key_t'(key_word[PKT_W-1:0]);
    k_hi = key_t'(key_word[2*PKT_W-1:PKT_W]);
    if (two_keys && (k_hi.prio > k_lo.prio)) rptr = k_hi.rptr;
    else                                     rptr = k_lo.rptr;
  end
endmodule

// File: rtl/ptw_step_guard.sv
module ptw_step_guard #(
  parameter int MAX_STEPS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last_step
);
  localparam int CNT_W = $clog2(MAX_STEPS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_step = step && (cnt_q == CNT_W'(MAX_STEPS - 1));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int MAX_BR    = 8,
  parameter int MAX_STEPS = 64,
  parameter int DROP_PTR  = 0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_valid,
  output logic                                   start_ready,
  input  logic [NPTR_W-1:0]                      start_node,
  input  logic [PPTR_W-1:0]                      start_pkt,
  input  logic [RPTR_W-1:0]                      def_ptr,
  output logic [PPTR_W-1:0]                      pkt_addr,
  input  logic [PKT_W-1:0]                       pkt_data,
  output logic [NPTR_W+$clog2(MAX_BR+1)-1:0]     node_addr,
  input  logic [WORD_W-1:0]                      node_data,
  output logic                                   result_valid,
  output logic [RPTR_W-1:0]                      result_ptr,
  output logic                                   result_drop,
  output logic                                   result_timeout
);
  localparam int SLOT_W = $clog2(MAX_BR + 1);
  localparam logic [BR_W-1:0] LAST_BR = BR_W'(MAX_BR - 1);

  walk_state_e       state_q, state_d;
  logic [NPTR_W-1:0] node_q, node_d;
  logic [BR_W-1:0]   br_q, br_d;
  logic [PPTR_W-1:0] ptr_q, ptr_d;
  logic [RPTR_W-1:0] hdr_rptr_q, hdr_rptr_d;
  logic              two_keys_q, two_keys_d;
  logic [RPTR_W-1:0] fallback_q;

  hdr_t              hdr;
  br_t               brw;
  logic              take;
  logic [PPTR_W-1:0] next_ptr;
  logic [RPTR_W-1:0] key_rptr;
  logic              accept;
  logic              stepping;
  logic              last_step;
  logic              natural_end;
  logic [RPTR_W-1:0] natural_ptr;
  logic              finish;
  logic [RPTR_W-1:0] finish_ptr;

  assign hdr         = hdr_t'(node_data);
  assign brw         = br_t'(node_data);
  assign start_ready = (state_q == S_IDLE);
  assign accept      = start_valid && start_ready;
  assign stepping    = (state_q != S_IDLE);
  assign pkt_addr    = ptr_q;

  always_comb begin
    case (state_q)
      S_HDR:   node_addr = {node_q, SLOT_W'(0)};
      S_BR:    node_addr = {node_q, SLOT_W'(br_q) + SLOT_W'(1)};
      S_KEY:   node_addr = {node_q, SLOT_W'(1)};
      default: node_addr = '0;
    endcase
  end

  ptw_branch_eval u_eval (
    .br       (brw),
    .pkt_word (pkt_data),
    .cur_ptr  (ptr_q),
    .take     (take),
    .next_ptr (next_ptr)
  );

  ptw_key_pick u_keys (
    .key_word (node_data[2*PKT_W-1:0]),
    .two_keys (two_keys_q),
    .rptr     (key_rptr)
  );

  ptw_step_guard #(.MAX_STEPS(MAX_STEPS)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .step      (stepping),
    .last_step (last_step)
  );

  always_comb begin
    state_d     = state_q;
    node_d      = node_q;
    br_d        = br_q;
    ptr_d       = ptr_q;
    hdr_rptr_d  = hdr_rptr_q;
    two_keys_d  = two_keys_q;
    natural_end = 1'b0;
    natural_ptr = hdr_rptr_q;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_d = S_HDR;
          node_d  = start_node;
          br_d    = '0;
          ptr_d   = start_pkt;
        end
      end
      S_HDR: begin
        hdr_rptr_d = hdr.rptr;
        two_keys_d = hdr.two_keys;
        if (hdr.last) begin
          natural_end = 1'b1;
          natural_ptr = hdr.rptr;
        end else if (hdr.kind == KIND_KEY) begin
          state_d = S_KEY;
        end else begin
          state_d = S_BR;
        end
      end
      S_BR: begin
        if (take) begin
          ptr_d = next_ptr;
          br_d  = brw.nbr;
          if (brw.nnode != node_q) begin
            node_d  = brw.nnode;
            state_d = S_HDR;
          end
        end else if (br_q >= LAST_BR) begin
          natural_end = 1'b1;
          natural_ptr = hdr_rptr_q;
        end else begin
          br_d = br_q + BR_W'(1);
        end
      end
      default: begin
        natural_end = 1'b1;
        natural_ptr = key_rptr;
      end
    endcase
    finish     = natural_end || last_step;
    finish_ptr = natural_end ? natural_ptr : fallback_q;
    if (finish) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= S_IDLE;
      node_q         <= '0;
      br_q           <= '0;
      ptr_q          <= '0;
      hdr_rptr_q     <= '0;
      two_keys_q     <= 1'b0;
      fallback_q     <= '0;
      result_valid   <= 1'b0;
      result_ptr     <= '0;
      result_drop    <= 1'b0;
      result_timeout <= 1'b0;
    end else begin
      state_q      <= state_d;
      node_q       <= node_d;
      br_q         <= br_d;
      ptr_q        <= ptr_d;
      hdr_rptr_q   <= hdr_rptr_d;
      two_keys_q   <= two_keys_d;
      result_valid <= finish;
      if (accept) fallback_q <= def_ptr;
      if (finish) begin
        result_ptr     <= finish_ptr;
        result_drop    <= (finish_ptr == RPTR_W'(DROP_PTR));
        result_timeout <= !natural_end;
      end
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
#(
  parameter int MAX_BR    = 8,
  parameter int MAX_STEPS = 64,
  parameter int DROP_PTR  = 0
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               start_valid,
  input logic                               start_ready,
  input logic [NPTR_W-1:0]                  start_node,
  input logic [PPTR_W-1:0]                  start_pkt,
  input logic [PPTR_W-1:0]                  pkt_addr,
  input logic [NPTR_W+$clog2(MAX_BR+1)-1:0] node_addr,
  input logic                               result_valid,
  input logic [RPTR_W-1:0]                  result_ptr,
  input logic                               result_drop,
  input logic                               result_timeout
);
  localparam int SLOT_W = $clog2(MAX_BR + 1);
  localparam int CNT_W  = $clog2(MAX_STEPS + 2);

  logic [CNT_W-1:0] walk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         walk_cnt <= '0;
    else if (start_valid && start_ready) walk_cnt <= '0;
    else if (!start_ready)              walk_cnt <= walk_cnt + CNT_W'(1);
  end

  p_taken_clears_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> !start_ready);

  p_header_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> node_addr == {$past(start_node), SLOT_W'(0)});

  p_start_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> pkt_addr == $past(start_pkt));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_step_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (walk_cnt >= CNT_W'(1)) && (walk_cnt <= CNT_W'(MAX_STEPS)));

  p_timeout_length_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && result_timeout |-> walk_cnt == CNT_W'(MAX_STEPS));

  p_drop_meaning_r11: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> result_drop == (result_ptr == RPTR_W'(DROP_PTR)));
endmodule

bind ptw_walker ptw_walker_chk #(
  .MAX_BR    (MAX_BR),
  .MAX_STEPS (MAX_STEPS),
  .DROP_PTR  (DROP_PTR)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_valid    (start_valid),
  .start_ready    (start_ready),
  .start_node     (start_node),
  .start_pkt      (start_pkt),
  .pkt_addr       (pkt_addr),
  .node_addr      (node_addr),
  .result_valid   (result_valid),
  .result_ptr     (result_ptr),
  .result_drop    (result_drop),
  .result_timeout (result_timeout)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [13:0] start_node = '0;
  logic [8:0]  start_pkt = '0;
  logic [9:0]  def_ptr = '0;
  logic [8:0]  pkt_addr;
  logic [15:0] pkt_data;
  logic [17:0] node_addr;
  logic [63:0] node_data;
  logic        result_valid;
  logic [9:0]  result_ptr;
  logic        result_drop;
  logic        result_timeout;

  logic [7:0]  pmem [0:511];
  logic [63:0] nmem [0:255];

  int total = 0;
  int bad = 0;
  int r_cyc;
  logic [9:0] r_ptr;
  logic r_drop, r_to;

  always #2 clk = ~clk;

  assign pkt_data  = {pmem[pkt_addr], pmem[pkt_addr + 9'd1]};
  assign node_data = nmem[node_addr[7:0]];

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_node(start_node), .start_pkt(start_pkt), .def_ptr(def_ptr),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .node_addr(node_addr), .node_data(node_data),
    .result_valid(result_valid), .result_ptr(result_ptr), .result_drop(result_drop),
    .result_timeout(result_timeout)
  );

  function automatic logic [63:0] mk_br(input logic v, input logic [8:0] npp, input logic back,
      input logic rel, input logic [1:0] op, input logic [13:0] nn, input logic [2:0] nb,
      input logic [15:0] data, input logic [15:0] mask);
    mk_br = {1'b0, v, npp, back, rel, op, nn, nb, data, mask};
  endfunction

  function automatic logic [63:0] mk_hdr(input logic [1:0] kind, input logic last,
      input logic two, input logic [6:0] stores, input logic [9:0] rptr);
    mk_hdr = {43'd0, kind, last, two, stores, rptr};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) pmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) nmem[i] = 64'd0;
  endtask

  task automatic put(input int node, input int slot, input logic [63:0] w);
    nmem[node*16 + slot] = w;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(input int node, input int pkt, input logic [9:0] dflt);
    @(negedge clk);
    start_node = 14'(node);
    start_pkt = 9'(pkt);
    def_ptr = dflt;
    start_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    r_cyc = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      r_cyc++;
      @(negedge clk);
      if (result_valid) break;
    end
    r_ptr = result_ptr;
    r_drop = result_drop;
    r_to = result_timeout;
    @(negedge clk);
    check("R7 pulse ends", {31'd0, result_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", {31'd0, start_ready}, 32'd1);
    check("R12 valid after reset", {31'd0, result_valid}, 32'd0);
  endtask

  task automatic t_last_node();
    clear_mem();
    put(3, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h2A));
    run_walk(3, 12, 10'h3FF);
    check("R8 last result", 32'(r_ptr), 32'h2A);
    check("R7 last cycles", r_cyc, 1);
    check("R10 no timeout", {31'd0, r_to}, 32'd0);
    put(3, 0, mk_hdr(2'd1, 1'b1, 1'b1, 7'd0, 10'h2B));
    run_walk(3, 12, 10'h3FF);
    check("R8 last beats key", 32'(r_ptr), 32'h2B);
    check("R8 last beats key cycles", r_cyc, 1);
    put(3, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'h7F, 10'h2A));
    run_walk(3, 12, 10'h3FF);
    check("R13 stores ignored result", 32'(r_ptr), 32'h2A);
    check("R13 stores ignored cycles", r_cyc, 1);
  endtask

  task automatic build_proto_tree();
    clear_mem();
    put(0, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'd0));
    put(0, 1, mk_br(1'b1, 9'd23, 1'b0, 1'b0, 2'd0, 14'd1, 3'd0, 16'h0800, 16'h0000));
    put(0, 2, mk_br(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 14'd6, 3'd0, 16'h0000, 16'hFFFF));
    put(1, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'h55, 10'd0));
    put(1, 1, mk_br(1'b1, 9'd26, 1'b0, 1'b0, 2'd0, 14'd2, 3'd0, 16'h0600, 16'h00FF));
    put(1, 2, mk_br(1'b1, 9'd26, 1'b0, 1'b0, 2'd0, 14'd4, 3'd0, 16'h1100, 16'h00FF));
    put(1, 3, mk_br(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 14'd6, 3'd0, 16'h0000, 16'hFFFF));
    put(2, 0, mk_hdr(2'd1, 1'b0, 1'b0, 7'd0, 10'h3A));
    put(2, 1, 64'h0000_0000_0000_2001);
    put(4, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h005));
    put(6, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h000));
    pmem[12] = 8'h08; pmem[13] = 8'h00;
  endtask

  task automatic t_proto_paths();
    build_proto_tree();
    pmem[23] = 8'h06; pmem[24] = 8'h9C;
    run_walk(0, 12, 10'h3FF);
    check("R9 tcp path key result", 32'(r_ptr), 32'h001);
    check("R7 tcp path cycles", r_cyc, 6);
    check("R11 accept not drop", {31'd0, r_drop}, 32'd0);
    pmem[23] = 8'h11;
    run_walk(0, 12, 10'h3FF);
    check("R6 udp second branch", 32'(r_ptr), 32'h005);
    check("R6 udp cycles", r_cyc, 6);
    pmem[23] = 8'h01;
    run_walk(0, 12, 10'h3FF);
    check("R4 catch-all result", 32'(r_ptr), 32'h000);
    check("R4 catch-all cycles", r_cyc, 7);
    check("R11 drop flag", {31'd0, r_drop}, 32'd1);
    pmem[12] = 8'h86; pmem[13] = 8'hDD;
    run_walk(0, 12, 10'h3FF);
    check("R3 ethertype mismatch cycles", r_cyc, 4);
    check("R11 mismatch drop", {31'd0, r_drop}, 32'd1);
  endtask

  task automatic one_op(input string req, input logic [1:0] op, input logic [15:0] data,
      input logic [15:0] mask, input logic exp_take);
    put(7, 1, mk_br(1'b1, 9'd0, 1'b0, 1'b0, op, 14'd8, 3'd0, data, mask));
    run_walk(7, 40, 10'h3FF);
    check(req, 32'(r_ptr), exp_take ? 32'h11 : 32'h22);
    check(req, r_cyc, exp_take ? 3 : 4);
  endtask

  task automatic t_compare_ops();
    clear_mem();
    put(7, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'h77));
    put(7, 2, mk_br(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 14'd9, 3'd0, 16'h0, 16'hFFFF));
    put(8, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h11));
    put(9, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h22));
    pmem[40] = 8'h12; pmem[41] = 8'h34;
    one_op("R3 eq masked", 2'd0, 16'h12FF, 16'h00FF, 1'b1);
    one_op("R3 eq unmasked miss", 2'd0, 16'h12FF, 16'h0000, 1'b0);
    one_op("R3 ne differ", 2'd1, 16'h1235, 16'h0000, 1'b1);
    one_op("R3 ne equal", 2'd1, 16'h1234, 16'h0000, 1'b0);
    one_op("R3 gt above", 2'd2, 16'h1233, 16'h0000, 1'b1);
    one_op("R3 gt equal", 2'd2, 16'h1234, 16'h0000, 1'b0);
    one_op("R3 lt below", 2'd3, 16'h1235, 16'h0000, 1'b1);
    one_op("R3 lt equal", 2'd3, 16'h1234, 16'h0000, 1'b0);
    one_op("R3 gt masked", 2'd2, 16'h10FF, 16'h00FF, 1'b1);
  endtask

  task automatic t_pointer_jumps();
    clear_mem();
    put(10, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'h7E));
    put(10, 1, mk_br(1'b0, 9'd4, 1'b0, 1'b1, 2'd0, 14'd10, 3'd1, 16'h0, 16'h0));
    put(10, 2, mk_br(1'b1, 9'd10, 1'b1, 1'b1, 2'd0, 14'd10, 3'd2, 16'hA1B2, 16'h0));
    put(10, 3, mk_br(1'b1, 9'd510, 1'b0, 1'b0, 2'd0, 14'd10, 3'd3, 16'hC3D4, 16'h0));
    put(10, 4, mk_br(1'b1, 9'd5, 1'b0, 1'b1, 2'd0, 14'd12, 3'd0, 16'hE5F6, 16'h0));
    for (int s = 5; s < 9; s++)
      put(10, s, mk_br(1'b1, 9'd0, 1'b0, 1'b0, 2'd0, 14'd9, 3'd0, 16'hFFFF, 16'h0));
    put(12, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'h7D));
    put(12, 1, mk_br(1'b1, 9'd0, 1'b0, 1'b0, 2'd0, 14'd8, 3'd0, 16'h1234, 16'h0));
    put(12, 2, mk_br(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 14'd9, 3'd0, 16'h0, 16'hFFFF));
    put(8, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h11));
    put(9, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h22));
    pmem[104] = 8'hA1; pmem[105] = 8'hB2;
    pmem[94]  = 8'hC3; pmem[95]  = 8'hD4;
    pmem[510] = 8'hE5; pmem[511] = 8'hF6;
    pmem[3]   = 8'h12; pmem[4]   = 8'h34;
    run_walk(10, 100, 10'h3FF);
    check("R5 jump chain result", 32'(r_ptr), 32'h11);
    check("R7 same-node chaining cycles", r_cyc, 8);
  endtask

  task automatic t_fall_off();
    clear_mem();
    put(13, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'h33));
    for (int s = 1; s < 9; s++)
      put(13, s, mk_br(1'b1, 9'd0, 1'b0, 1'b0, 2'd0, 14'd9, 3'd0, 16'hFFFF, 16'h0));
    put(9, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h22));
    pmem[40] = 8'h12; pmem[41] = 8'h34;
    run_walk(13, 40, 10'h3FF);
    check("R6 fall-off default", 32'(r_ptr), 32'h33);
    check("R6 fall-off cycles", r_cyc, 9);
    check("R10 fall-off no timeout", {31'd0, r_to}, 32'd0);
  endtask

  task automatic t_keys();
    clear_mem();
    put(14, 0, mk_hdr(2'd1, 1'b0, 1'b1, 7'd0, 10'h3A));
    put(14, 1, {32'd0, 3'd5, 3'd0, 10'h041, 3'd2, 3'd0, 10'h040});
    run_walk(14, 0, 10'h3FF);
    check("R9 higher key1 wins", 32'(r_ptr), 32'h041);
    check("R9 key cycles", r_cyc, 2);
    put(14, 0, mk_hdr(2'd1, 1'b0, 1'b0, 7'd0, 10'h3A));
    run_walk(14, 0, 10'h3FF);
    check("R9 single key", 32'(r_ptr), 32'h040);
    put(14, 0, mk_hdr(2'd1, 1'b0, 1'b1, 7'd0, 10'h3A));
    put(14, 1, {32'd0, 3'd2, 3'd0, 10'h041, 3'd2, 3'd0, 10'h040});
    run_walk(14, 0, 10'h3FF);
    check("R9 tie keeps key0", 32'(r_ptr), 32'h040);
  endtask

  task automatic t_timeout();
    clear_mem();
    put(15, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'h3C));
    put(15, 1, mk_br(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 14'd15, 3'd0, 16'h0, 16'hFFFF));
    run_walk(15, 12, 10'h2FF);
    check("R10 timeout result", 32'(r_ptr), 32'h2FF);
    check("R10 timeout flag", {31'd0, r_to}, 32'd1);
    check("R10 timeout cycles", r_cyc, 64);
    run_walk(15, 12, 10'h000);
    check("R11 timeout drop", {31'd0, r_drop}, 32'd1);
  endtask

  task automatic t_busy_ignore();
    clear_mem();
    put(15, 0, mk_hdr(2'd0, 1'b0, 1'b0, 7'd0, 10'h3C));
    put(15, 1, mk_br(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 14'd15, 3'd0, 16'h0, 16'hFFFF));
    put(3, 0, mk_hdr(2'd0, 1'b1, 1'b0, 7'd0, 10'h2A));
    @(negedge clk);
    start_node = 14'd15; start_pkt = 9'd12; def_ptr = 10'h155; start_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    r_cyc = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      r_cyc++;
      @(negedge clk);
      if (r_cyc == 5) begin
        check("R1 busy not ready", {31'd0, start_ready}, 32'd0);
        start_node = 14'd3; def_ptr = 10'h0AA; start_valid = 1'b1;
      end
      if (r_cyc == 10) start_valid = 1'b0;
      if (result_valid) break;
    end
    check("R1 busy request ignored", 32'(result_ptr), 32'h155);
    check("R1 busy walk length", r_cyc, 64);
    check("R1 ready with result", {31'd0, start_ready}, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_last_node();
    t_proto_paths();
    t_compare_ops();
    t_pointer_jumps();
    t_fall_off();
    t_keys();
    t_timeout();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule